// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Poller

This block collects interrupt requests from two active-low external pins and a set of internal request strobes. It holds each one as a pending flag. At the end of every instruction it decides whether a vector request goes to the processor core. The core supplies three timing inputs: a strobe for the second-to-last clock of the running instruction, a strobe for its final clock, and a flag that marks a one-clock instruction. The block returns a one-cycle request together with the index of the winning source.

A flag only takes part in a decision if it was already present at a fixed point before the boundary:
- For a multi-cycle instruction, that point is the instruction's own second-to-last clock.
- For a one-clock instruction, that point is the final clock of the instruction before it.

A flag that misses this point is not lost. It stays pending and competes at the next boundary.

The external pins are sampled on every clock through a synchroniser. Each pin can detect either a falling edge or a low level. The core acknowledges a request by returning its index, which clears the edge flag of that source.

Top module: `irq_boundary_poller`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_req` is 0 and `irq_idx` is 0. All pending flags start cleared.
- R2: Each external pin passes through a two-flop synchroniser clocked every cycle. In edge mode (`ext_trig_fall[i]`=1), a high-to-low change between two consecutive synchronised samples sets flag i. A pin that falls before clock edge k has its flag set after edge k+2.
- R3: In level mode (`ext_trig_fall[i]`=0), flag i equals the inverse of the synchronised pin. An acknowledge does not clear it.
- R4: Internal source j has index j+2. If `int_req[j]` is high at a clock edge, its flag is set at that edge and stays set until it is acknowledged.
- R5: For an instruction with two or more cycles, a flag qualifies only if it is set during the cycle in which `cyc_penult` is high.
- R6: For a one-clock instruction (`single_cyc`=1 together with `cyc_last`), a flag qualifies only if it was set during the previous instruction's `cyc_last` cycle.
- R7: A flag that does not qualify at a boundary stays pending and is considered at the next boundary.
- R8: Among qualified candidates, the lowest index wins. External pin 0 has index 0, external pin 1 has index 1, and internal sources follow.
- R9: `irq_req` is high for exactly the cycle after a `cyc_last` cycle that had a candidate, and `irq_idx` carries the winner in that cycle. At all other times `irq_req` is 0 and `irq_idx` is 0.
- R10: When `global_en` is 0 no request is made. A source whose `src_en` bit is 0 is never selected. Flags that are masked in either way stay pending.
- R11: When `ack` is high with `ack_idx`=i, the flag of edge source i is cleared at that edge. If a new set event arrives in the same cycle, the set wins.
- R12: A qualified flag is a candidate only if it is still set in the `cyc_last` cycle. A flag that was acknowledged or a level that was released in between produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 2 | Active-low external interrupt pins |
| ext_trig_fall | input | 2 | Per pin: 1 = falling-edge mode, 0 = low-level mode |
| int_req | input | NUM_INT | Internal request strobes |
| src_en | input | NUM_INT+2 | Per-source enable mask |
| global_en | input | 1 | Master enable for requests |
| cyc_penult | input | 1 | High in the second-to-last clock of the instruction |
| cyc_last | input | 1 | High in the final clock of the instruction |
| single_cyc | input | 1 | The current instruction is one clock long |
| ack | input | 1 | Acknowledge strobe from the core |
| ack_idx | input | IDX_W | Index of the source being acknowledged |
| irq_req | output | 1 | One-cycle vector request |
| irq_idx | output | IDX_W | Winning source index |

## Verification
An internal strobe is visible in the flag one edge later. A pin change reaches the flag after three edges: two synchroniser stages and the flag register. A decision made in the `cyc_last` cycle shows up on `irq_req` and `irq_idx` one edge after that cycle. The reference model in the bench follows these delays exactly: it updates its own flags, snapshots and expected outputs at every rising edge from the inputs present at that edge. The comparison runs 1 ns after each edge, so every expected value is compared in the cycle where the design's registered output changes. Directed sequences place strobes and pin edges just before and just after the qualifying cycle of both instruction kinds, and a long random sequence covers the remaining interleavings.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
   // Number of dedicated external pins; they occupy the lowest indices.
   localparam int unsigned EXT_PINS = 2;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_FALL  = 1'b1
   } trig_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic cur_o,
   output logic prev_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1] is the synchronised sample, chain[STAGES] the one before it
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){IDLE}};
      else        chain <= {chain[STAGES-1:0], pin_i};
   end

   assign cur_o  = chain[STAGES-1];
   assign prev_o = chain[STAGES];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
   import irq_poll_pkg::*;
#(
   parameter int unsigned N_SRC = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [EXT_PINS-1:0]       ext_cur,
   input  logic [EXT_PINS-1:0]       ext_prev,
   input  logic [EXT_PINS-1:0]       ext_mode,
   input  logic [N_SRC-EXT_PINS-1:0] int_req,
   input  logic                      ack,
   input  logic [IDX_W-1:0]          ack_idx,
   output logic [N_SRC-1:0]          flags_o
);
   generate
      if (N_SRC <= EXT_PINS) begin : g_bad_count
         $error("irq_flag_bank: at least one internal source required");
      end
      if ((1 << IDX_W) < N_SRC) begin : g_bad_width
         $error("irq_flag_bank: IDX_W too narrow for N_SRC");
      end
   endgenerate

   logic [N_SRC-1:0] flag_q;
   logic [N_SRC-1:0] flag_d;

   genvar gi;
   generate
      for (gi = 0; gi < N_SRC; gi++) begin : g_src
         logic hit;
         assign hit = ack && (ack_idx == IDX_W'(gi));
         if (gi < EXT_PINS) begin : g_pin
            logic fall;
            assign fall = ext_prev[gi] & ~ext_cur[gi];
            always_comb begin
               if (trig_e'(ext_mode[gi]) == TRIG_FALL)
                  flag_d[gi] = fall | (flag_q[gi] & ~hit);
               else
                  flag_d[gi] = ~ext_cur[gi];
            end
         end else begin : g_int
            assign flag_d[gi] = int_req[gi-EXT_PINS] | (flag_q[gi] & ~hit);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign flags_o = flag_q;
endmodule

// File: rtl/irq_boundary_qual.sv
module irq_boundary_qual #(
   parameter int unsigned N_SRC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] flags_i,
   input  logic             cyc_penult,
   input  logic             cyc_last,
   input  logic             single_cyc,
   output logic [N_SRC-1:0] qual_o
);
   // Two snapshots: one taken at the end of the second-to-last cycle, one at
   // the end of the final cycle (used by a following one-clock instruction).
   logic [N_SRC-1:0] snap_pen_q;
   logic [N_SRC-1:0] snap_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_pen_q  <= '0;
         snap_last_q <= '0;
      end else begin
         if (cyc_penult) snap_pen_q  <= flags_i;
         if (cyc_last)   snap_last_q <= flags_i;
      end
   end

   assign qual_o = single_cyc ? snap_last_q : snap_pen_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N_SRC = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N_SRC-1:0] cand_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = |cand_i;
      idx_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (cand_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_boundary_poller.sv
module irq_boundary_poller
   import irq_poll_pkg::*;
#(
   parameter  int unsigned NUM_INT     = 4,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned N_SRC       = EXT_PINS + NUM_INT,
   localparam int unsigned IDX_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [EXT_PINS-1:0] ext_irq_n,
   input  logic [EXT_PINS-1:0] ext_trig_fall,
   input  logic [NUM_INT-1:0]  int_req,
   input  logic [N_SRC-1:0]    src_en,
   input  logic                global_en,
   input  logic                cyc_penult,
   input  logic                cyc_last,
   input  logic                single_cyc,
   input  logic                ack,
   input  logic [IDX_W-1:0]    ack_idx,
   output logic                irq_req,
   output logic [IDX_W-1:0]    irq_idx
);
   generate
      if (NUM_INT < 1) begin : g_bad_int
         $error("irq_boundary_poller: NUM_INT must be at least 1");
      end
   endgenerate

   logic [EXT_PINS-1:0] pin_cur;
   logic [EXT_PINS-1:0] pin_prev;
   logic [N_SRC-1:0]    flag_vec;
   logic [N_SRC-1:0]    qual_vec;
   logic [N_SRC-1:0]    cand_vec;
   logic                pick_any;
   logic [IDX_W-1:0]    pick_idx;
   logic                fire;

   genvar gp;
   generate
      for (gp = 0; gp < EXT_PINS; gp++) begin : g_pin
         irq_pin_sync #(
            .STAGES (SYNC_STAGES),
            .IDLE   (1'b1)
         ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_irq_n[gp]),
            .cur_o  (pin_cur[gp]),
            .prev_o (pin_prev[gp])
         );
      end
   endgenerate

   irq_flag_bank #(
      .N_SRC (N_SRC),
      .IDX_W (IDX_W)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_cur  (pin_cur),
      .ext_prev (pin_prev),
      .ext_mode (ext_trig_fall),
      .int_req  (int_req),
      .ack      (ack),
      .ack_idx  (ack_idx),
      .flags_o  (flag_vec)
   );

   irq_boundary_qual #(
      .N_SRC (N_SRC)
   ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .flags_i    (flag_vec),
      .cyc_penult (cyc_penult),
      .cyc_last   (cyc_last),
      .single_cyc (single_cyc),
      .qual_o     (qual_vec)
   );

   // qualified at the latch point, still pending now, and allowed by both masks
   assign cand_vec = qual_vec & flag_vec & src_en & {N_SRC{global_en}};

   irq_prio_pick #(
      .N_SRC (N_SRC),
      .IDX_W (IDX_W)
   ) u_pick (
      .cand_i (cand_vec),
      .any_o  (pick_any),
      .idx_o  (pick_idx)
   );

   assign fire = cyc_last & pick_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_idx <= '0;
      end else begin
         irq_req <= fire;
         irq_idx <= fire ? pick_idx : '0;
      end
   end
endmodule

// File: rtl/irq_boundary_poller_chk.sv
module irq_boundary_poller_chk #(
   parameter int unsigned N_SRC = 6,
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_last,
   input logic             global_en,
   input logic [N_SRC-1:0] src_en,
   input logic             irq_req,
   input logic [IDX_W-1:0] irq_idx,
   input logic [N_SRC-1:0] cand_vec,
   input logic [N_SRC-1:0] flag_vec
);
   p_req_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(cyc_last));

   p_idle_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_idx == '0));

   p_global_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(global_en));

   p_source_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((($past(src_en) >> irq_idx) & N_SRC'(1)) != '0));

   p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (($past(cand_vec) & ((N_SRC'(1) << irq_idx) - N_SRC'(1))) == '0));

   p_winner_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((($past(flag_vec) >> irq_idx) & N_SRC'(1)) != '0));
endmodule

bind irq_boundary_poller irq_boundary_poller_chk #(
   .N_SRC (N_SRC),
   .IDX_W (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_last  (cyc_last),
   .global_en (global_en),
   .src_en    (src_en),
   .irq_req   (irq_req),
   .irq_idx   (irq_idx),
   .cand_vec  (cand_vec),
   .flag_vec  (flag_vec)
);

// File: tb/test_irq_boundary_poller.sv
`timescale 1ns/1ps
module test_irq_boundary_poller;
   localparam int NI  = 4;
   localparam int NS  = NI + 2;
   localparam int IW  = 3;
   localparam real HALF = 2.5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    ext_irq_n = 2'b11;
   logic [1:0]    ext_trig_fall = 2'b11;
   logic [NI-1:0] int_req = '0;
   logic [NS-1:0] src_en = '1;
   logic          global_en = 1'b1;
   logic          cyc_penult = 1'b0;
   logic          cyc_last = 1'b0;
   logic          single_cyc = 1'b0;
   logic          ack = 1'b0;
   logic [IW-1:0] ack_idx = '0;
   logic          irq_req;
   logic [IW-1:0] irq_idx;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 0;
   bit    auto_ack = 0;
   string cur_req = "R1";

   always #(HALF) clk = ~clk;

   irq_boundary_poller #(.NUM_INT(NI), .SYNC_STAGES(2)) i_irq_boundary_poller (
      .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .ext_trig_fall(ext_trig_fall),
      .int_req(int_req), .src_en(src_en), .global_en(global_en),
      .cyc_penult(cyc_penult), .cyc_last(cyc_last), .single_cyc(single_cyc),
      .ack(ack), .ack_idx(ack_idx), .irq_req(irq_req), .irq_idx(irq_idx));

   // ---------------- behavioural reference model ----------------
   bit  pin_hist [2][$];   // newest sample at the front, per pin
   bit  m_flag [NS];
   bit  m_snap_pen [NS];
   bit  m_snap_last [NS];
   bit  exp_req = 0;
   int  exp_idx = 0;

   initial begin
      for (int p = 0; p < 2; p++) pin_hist[p] = '{1'b1, 1'b1, 1'b1};
   end

   always @(posedge clk) begin : model
      bit nf [NS];
      bit hit;
      bit fall;
      int win;
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_flag[i] = 0; m_snap_pen[i] = 0; m_snap_last[i] = 0;
         end
         for (int p = 0; p < 2; p++) pin_hist[p] = '{1'b1, 1'b1, 1'b1};
         exp_req = 0; exp_idx = 0;
      end else begin
         // decision from the state held during the cycle that just ended
         win = -1;
         if (cyc_last) begin
            for (int i = NS - 1; i >= 0; i--) begin
               if ((single_cyc ? m_snap_last[i] : m_snap_pen[i]) && m_flag[i]
                   && src_en[i] && global_en)
                  win = i;
            end
         end
         exp_req = (win >= 0);
         exp_idx = (win >= 0) ? win : 0;
         // next flags
         for (int i = 0; i < NS; i++) begin
            hit = ack && (int'(ack_idx) == i);
            if (i < 2) begin
               fall = pin_hist[i][2] && !pin_hist[i][1];
               if (ext_trig_fall[i]) nf[i] = fall || (m_flag[i] && !hit);
               else                  nf[i] = !pin_hist[i][1];
            end else begin
               nf[i] = int_req[i-2] || (m_flag[i] && !hit);
            end
         end
         for (int i = 0; i < NS; i++) begin
            if (cyc_penult) m_snap_pen[i]  = m_flag[i];
            if (cyc_last)   m_snap_last[i] = m_flag[i];
            m_flag[i] = nf[i];
         end
         for (int p = 0; p < 2; p++) begin
            pin_hist[p].push_front(ext_irq_n[p]);
            void'(pin_hist[p].pop_back());
         end
      end
   end

   // compare every cycle, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (!done) begin
         n_checks++;
         if (irq_req !== exp_req || int'(irq_idx) !== exp_idx) begin
            n_fail++;
            $display("FAIL %s at %0t: req/idx actual %0b/%0d expected %0b/%0d",
                     cur_req, $time, irq_req, irq_idx, exp_req, exp_idx);
         end
      end
   end

   // one instruction of len cycles; int_req pulse in cycle pulse_at
   task automatic instr(input int len, input int pulse_at, input logic [NI-1:0] pulse);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         cyc_penult = (len >= 2) && (k == len - 2);
         cyc_last   = (k == len - 1);
         single_cyc = (len == 1);
         int_req    = (k == pulse_at) ? pulse : '0;
         ack        = auto_ack && exp_req;
         ack_idx    = IW'(exp_idx);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cyc_penult = 0; cyc_last = 0; single_cyc = 0; int_req = '0;
         ack = auto_ack && exp_req; ack_idx = IW'(exp_idx);
      end
   endtask

   initial begin : watchdog
      #(2.0 * HALF * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R4, R9: internal strobe before penult cycle -> request after last
      cur_req = "R4/R9";
      auto_ack = 1;
      instr(3, 0, 4'b0001);
      instr(2, -1, '0);
      idle(2);

      // R5, R7: strobe in penult cycle misses this boundary, taken at next
      cur_req = "R5/R7";
      instr(3, 1, 4'b0010);
      instr(2, -1, '0);
      instr(2, -1, '0);
      idle(2);

      // R6: one-clock instructions use the previous last-cycle snapshot
      cur_req = "R6";
      instr(2, 1, 4'b0100);
      instr(1, -1, '0);
      instr(1, -1, '0);
      instr(1, -1, '0);
      idle(2);

      // R8: several sources at once, lowest index first
      cur_req = "R8";
      instr(3, 0, 4'b1111);
      for (int k = 0; k < 6; k++) instr(2, -1, '0);
      idle(2);

      // R2: falling edges on both pins
      cur_req = "R2";
      ext_trig_fall = 2'b11;
      ext_irq_n = 2'b10;
      instr(4, -1, '0);
      ext_irq_n = 2'b11;
      instr(3, -1, '0);
      ext_irq_n = 2'b00;
      instr(2, -1, '0);
      instr(4, -1, '0);
      ext_irq_n = 2'b11;
      instr(3, -1, '0);
      instr(3, -1, '0);
      idle(2);

      // R3, R12: level pin stays pending through acks, release cancels
      cur_req = "R3/R12";
      ext_trig_fall = 2'b00;
      ext_irq_n = 2'b01;
      for (int k = 0; k < 4; k++) instr(3, -1, '0);
      instr(3, -1, '0);
      ext_irq_n = 2'b11;   // released during the final cycle window
      instr(3, -1, '0);
      instr(3, -1, '0);
      idle(4);

      // R10: masks keep flags pending
      cur_req = "R10";
      ext_trig_fall = 2'b11;
      global_en = 0;
      instr(3, 0, 4'b0011);
      instr(3, -1, '0);
      global_en = 1;
      src_en = 6'b111011;  // mask index 2
      instr(3, -1, '0);
      instr(3, -1, '0);
      src_en = '1;
      instr(3, -1, '0);
      instr(3, -1, '0);
      idle(2);

      // R11: manual ack clears edge flag; set in the same cycle wins
      cur_req = "R11";
      auto_ack = 0;
      instr(3, 0, 4'b0001);
      instr(3, -1, '0);
      @(negedge clk);
      cyc_penult = 0; cyc_last = 0; ack = 1; ack_idx = 3'd2; int_req = 4'b0001;
      @(negedge clk);
      ack = 1; ack_idx = 3'd2; int_req = '0;
      @(negedge clk);
      ack = 0;
      instr(3, -1, '0);
      @(negedge clk);
      ack = 1; ack_idx = 3'd3;
      instr(3, -1, '0);
      ack = 0;
      instr(3, -1, '0);
      idle(2);

      // random mix over all requirements
      cur_req = "R2-R12 random";
      for (int n = 0; n < 1500; n++) begin
         auto_ack      = ($urandom_range(0, 3) != 0);
         global_en     = ($urandom_range(0, 7) != 0);
         src_en        = NS'($urandom_range(0, 63)) | NS'(6'b100101);
         ext_trig_fall = 2'($urandom_range(0, 3));
         ext_irq_n     = 2'($urandom_range(0, 3));
         instr($urandom_range(1, 4), $urandom_range(0, 4), NI'($urandom_range(0, 15)));
         if ($urandom_range(0, 9) == 0) begin
            @(negedge clk);
            cyc_penult = 0; cyc_last = 0; int_req = '0;
            ack = 1; ack_idx = IW'($urandom_range(0, NS - 1));
         end
      end
      idle(3);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule